// File: doc/BRIEF.md
# Fan PWM Override and Thermal Lock Controller

This block drives one fan PWM channel. It holds an 8-bit control register that software reaches through a simple register bus at one fixed address. It then chooses the duty level for the channel. Several automatic control sources each request a 4-bit duty code. When the override is enabled, the manual override code joins them as one more request. The highest request wins.

A processor-hot event can arm a sticky thermal lock. While the lock is set, the channel stays at full duty until software clears the flag. The duty field of the register reads back the code that is in effect now, not the code that was written. During fan spin-up that field reads as zero.

The chosen code is turned into a PWM waveform. The period is 256 prescaled ticks. The compare level is loaded only at the start of a period, so a duty change never produces a runt pulse. The output polarity is set in the register.

Top module: `fan_pwm_ovr_ctrl`

## Requirements
- R1: After reset the register reads 00h, `duty_code` is 0h and `pwm_out` is low.
- R2: A write to `REG_ADDR` with `cfg_lock` low loads the fields at these bit positions: bit 0 is override enable, bit 1 is invert, bit 2 is lock arm, and bits 7:4 are the override code. The register reads back as {duty[3:0], lock flag, lock arm, invert, override enable}.
- R3: `duty_code` is the largest of the `NUM_SRC` automatic requests and, when override enable is 1, the override code. Request i sits in `auto_req[4*i+3:4*i]`.
- R4: If lock arm was 1 in a cycle where `hot_evt` is high, the lock flag (bit 3) is set on the next edge. If lock arm is 0, `hot_evt` never sets it.
- R5: While the lock flag is set, `duty_code` is Fh, whatever the other requests are.
- R6: The lock flag is cleared only by a register write with bit 3 equal to 0. Writing 1 to bit 3 has no effect. If `hot_evt` and the clearing write arrive in the same cycle, the flag stays set.
- R7: While `cfg_lock` is high, a write leaves bits 0, 1, 2 and 7:4 unchanged, but a 0 in bit 3 still clears the lock flag.
- R8: With `bus_addr` equal to `REG_ADDR`, `bus_rdata[7:4]` shows the current `duty_code`, or 0h while `spin_req` is high. Any other address reads 00h.
- R9: The PWM period is 256×`PRESCALE` clocks. Code c gives a compare level of 17·c, except that code Fh covers the whole period. With invert at 0 the output is high for compare×`PRESCALE` clocks in each period. With invert at 1 the output is the complement.
- R10: The compare level changes only at a period boundary. At that boundary it is loaded from `duty_code`, or from Fh while `spin_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| cfg_lock | input | 1 | Global write protection for the non-lock fields |
| auto_req | input | 4*NUM_SRC | Duty requests from automatic sources |
| hot_evt | input | 1 | Bound processor-hot event |
| spin_req | input | 1 | Spin-up in progress |
| duty_code | output | 4 | Duty code currently selected |
| pwm_out | output | 1 | PWM waveform |

## Verification
The bench goes after the race between a processor-hot event and a clearing write in the same cycle. A design that lets the write win would drop the lock and cool the fan at the wrong moment. It checks that `cfg_lock` protects the other fields but not the lock flag. A design that protects the whole byte could never be unlocked by software. It checks that readback shows the arbitrated code, so that a design echoing the stored value shows a low duty while a higher automatic request is in effect. PWM high-time counts are compared against the compare-level formula for a normal code, for full duty, and for inverted polarity. Every output is also compared each clock against a behavioural model, which catches a compare level loaded in mid-period.

// File: rtl/fan_pwm_pkg.sv
package fan_pwm_pkg;
    localparam int CODE_W = 4;

    typedef struct packed {
        logic [CODE_W-1:0] ovr_code;
        logic              lock_flag;
        logic              lock_arm;
        logic              inv_on;
        logic              ovr_on;
    } ctl_reg_t;
endpackage

// File: rtl/fan_duty_arb.sv
module fan_duty_arb #(
    parameter int NUM_SRC = 3,
    parameter int CODE_W  = 4
) (
    input  logic [NUM_SRC*CODE_W-1:0] auto_req,
    input  logic                      ovr_on,
    input  logic [CODE_W-1:0]         ovr_code,
    input  logic                      lock_flag,
    output logic [CODE_W-1:0]         sel_code
);
    logic [CODE_W-1:0] best;

    always_comb begin
        best = ovr_on ? ovr_code : '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (auto_req[i*CODE_W +: CODE_W] > best) begin
                best = auto_req[i*CODE_W +: CODE_W];
            end
        end
        if (lock_flag) begin
            best = '1;
        end
        sel_code = best;
    end
endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen #(
    parameter int PRESCALE = 2,
    parameter int PERIOD_W = 8,
    parameter int CODE_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_in,
    input  logic              inv_on,
    output logic              pwm_out,
    output logic              period_start,
    output logic [PERIOD_W:0] cmp_level
);
    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam int CMP_W = PERIOD_W + 1;
    localparam int STEP  = ((1 << PERIOD_W) - 1) / ((1 << CODE_W) - 1);
    localparam logic [CMP_W-1:0] FULL = CMP_W'(1 << PERIOD_W);

    typedef struct packed {
        logic [PRE_W-1:0]    pre;
        logic [PERIOD_W-1:0] cnt;
        logic [CMP_W-1:0]    cmp;
    } gen_st_t;

    gen_st_t st_d, st_q;
    logic    tick;

    function automatic logic [CMP_W-1:0] code_to_cmp(input logic [CODE_W-1:0] c);
        if (c == '1) begin
            return FULL;
        end
        return CMP_W'(c) * CMP_W'(STEP);
    endfunction

    assign tick         = (st_q.pre == PRE_W'(PRESCALE - 1));
    assign period_start = tick && (st_q.cnt == '1);

    always_comb begin
        st_d = st_q;
        if (tick) begin
            st_d.pre = '0;
            st_d.cnt = st_q.cnt + 1'b1;
        end else begin
            st_d.pre = st_q.pre + 1'b1;
        end
        if (period_start) begin
            st_d.cmp = code_to_cmp(code_in);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmp_level = st_q.cmp;
    assign pwm_out   = ({1'b0, st_q.cnt} < st_q.cmp) ^ inv_on;
endmodule

// File: rtl/fan_pwm_ovr_ctrl.sv
module fan_pwm_ovr_ctrl
    import fan_pwm_pkg::*;
#(
    parameter int          NUM_SRC  = 3,
    parameter int          PRESCALE = 2,
    parameter int          PERIOD_W = 8,
    parameter logic [7:0]  REG_ADDR = 8'h2A
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_wr,
    input  logic [7:0]                bus_addr,
    input  logic [7:0]                bus_wdata,
    output logic [7:0]                bus_rdata,
    input  logic                      cfg_lock,
    input  logic [NUM_SRC*CODE_W-1:0] auto_req,
    input  logic                      hot_evt,
    input  logic                      spin_req,
    output logic [CODE_W-1:0]         duty_code,
    output logic                      pwm_out
);
    ctl_reg_t          reg_d, reg_q;
    logic              hit;
    logic              lock_flag, lock_arm, ovr_on, inv_on;
    logic [CODE_W-1:0] ovr_code;
    logic [CODE_W-1:0] sel_code;
    logic [CODE_W-1:0] gen_code;
    logic              period_start;
    logic [PERIOD_W:0] cmp_level;

    assign hit = bus_wr && (bus_addr == REG_ADDR);

    always_comb begin
        reg_d = reg_q;
        if (hit && !cfg_lock) begin
            reg_d.ovr_on   = bus_wdata[0];
            reg_d.inv_on   = bus_wdata[1];
            reg_d.lock_arm = bus_wdata[2];
            reg_d.ovr_code = bus_wdata[7:4];
        end
        if (hit && !bus_wdata[3]) begin
            reg_d.lock_flag = 1'b0;
        end
        if (hot_evt && reg_q.lock_arm) begin
            reg_d.lock_flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign lock_flag = reg_q.lock_flag;
    assign lock_arm  = reg_q.lock_arm;
    assign ovr_on    = reg_q.ovr_on;
    assign inv_on    = reg_q.inv_on;
    assign ovr_code  = reg_q.ovr_code;

    fan_duty_arb #(
        .NUM_SRC (NUM_SRC),
        .CODE_W  (CODE_W)
    ) u_arb (
        .auto_req  (auto_req),
        .ovr_on    (ovr_on),
        .ovr_code  (ovr_code),
        .lock_flag (lock_flag),
        .sel_code  (sel_code)
    );

    assign duty_code = sel_code;
    assign gen_code  = spin_req ? '1 : sel_code;

    fan_pwm_gen #(
        .PRESCALE (PRESCALE),
        .PERIOD_W (PERIOD_W),
        .CODE_W   (CODE_W)
    ) u_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .code_in      (gen_code),
        .inv_on       (inv_on),
        .pwm_out      (pwm_out),
        .period_start (period_start),
        .cmp_level    (cmp_level)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == REG_ADDR) begin
            bus_rdata = {spin_req ? {CODE_W{1'b0}} : sel_code,
                         lock_flag, lock_arm, inv_on, ovr_on};
        end
    end
endmodule

// File: rtl/fan_pwm_ovr_chk.sv
module fan_pwm_ovr_chk #(
    parameter int         NUM_SRC  = 3,
    parameter int         PERIOD_W = 8,
    parameter logic [7:0] REG_ADDR = 8'h2A
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_wr,
    input logic [7:0]            bus_addr,
    input logic                  wr_clr_n,
    input logic [3:0]            rd_code,
    input logic                  cfg_lock,
    input logic [NUM_SRC*4-1:0]  auto_req,
    input logic                  hot_evt,
    input logic                  spin_req,
    input logic [3:0]            duty_code,
    input logic                  lock_flag,
    input logic                  lock_arm,
    input logic                  ovr_on,
    input logic                  inv_on,
    input logic [3:0]            ovr_code,
    input logic                  period_start,
    input logic [PERIOD_W:0]     cmp_level
);
    logic hit;
    assign hit = bus_wr && (bus_addr == REG_ADDR);

    AST_LOCK_SET_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_flag) |-> ($past(hot_evt) && $past(lock_arm))); // R4

    AST_LOCK_FULL_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
        lock_flag |-> (duty_code == 4'hF)); // R5

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_flag && !(hit && wr_clr_n == 1'b0)) |=> lock_flag); // R6

    AST_CFG_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && cfg_lock) |=> ($stable(ovr_on) && $stable(inv_on) &&
                               $stable(lock_arm) && $stable(ovr_code))); // R7

    AST_SPIN_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (spin_req && bus_addr == REG_ADDR) |-> (rd_code == 4'h0)); // R8

    AST_CMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !period_start |=> $stable(cmp_level)); // R10

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_req
        AST_DUTY_COVERS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
            duty_code >= auto_req[i*4 +: 4]); // R3
    end
endmodule

bind fan_pwm_ovr_ctrl fan_pwm_ovr_chk #(
    .NUM_SRC  (NUM_SRC),
    .PERIOD_W (PERIOD_W),
    .REG_ADDR (REG_ADDR)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .wr_clr_n     (bus_wdata[3]),
    .rd_code      (bus_rdata[7:4]),
    .cfg_lock     (cfg_lock),
    .auto_req     (auto_req),
    .hot_evt      (hot_evt),
    .spin_req     (spin_req),
    .duty_code    (duty_code),
    .lock_flag    (lock_flag),
    .lock_arm     (lock_arm),
    .ovr_on       (ovr_on),
    .inv_on       (inv_on),
    .ovr_code     (ovr_code),
    .period_start (period_start),
    .cmp_level    (cmp_level)
);

// File: tb/fan_pwm_ovr_ctrl_tb.sv
module fan_pwm_ovr_ctrl_tb;
    localparam int         NSRC = 3;
    localparam int         PRE  = 2;
    localparam logic [7:0] ADR  = 8'h2A;
    localparam int         PER  = 256 * PRE;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_wr = 1'b0;
    logic [7:0]      bus_addr = ADR;
    logic [7:0]      bus_wdata = 8'h00;
    logic [7:0]      bus_rdata;
    logic            cfg_lock = 1'b0;
    logic [3:0]      req [NSRC];
    logic [NSRC*4-1:0] auto_req;
    logic            hot_evt = 1'b0;
    logic            spin_req = 1'b0;
    logic [3:0]      duty_code;
    logic            pwm_out;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NSRC; i++) auto_req[i*4 +: 4] = req[i];
    end

    fan_pwm_ovr_ctrl #(.NUM_SRC(NSRC), .PRESCALE(PRE), .REG_ADDR(ADR)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_lock(cfg_lock),
        .auto_req(auto_req), .hot_evt(hot_evt), .spin_req(spin_req),
        .duty_code(duty_code), .pwm_out(pwm_out)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // behavioural reference model
    int m_n, m_code, m_cmp;
    bit m_ovr, m_inv, m_arm, m_lock;

    function automatic int f_duty();
        int best = m_ovr ? m_code : 0;
        for (int i = 0; i < NSRC; i++) if (int'(req[i]) > best) best = int'(req[i]);
        if (m_lock) best = 15;
        return best;
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            m_n = 0; m_code = 0; m_cmp = 0;
            m_ovr = 0; m_inv = 0; m_arm = 0; m_lock = 0;
        end else begin
            int ed, erd, cnt, c;
            bit ep, old_arm;
            ed = f_duty();
            chk(int'(duty_code) == ed, "R3", "duty_code model", duty_code, ed);
            erd = (bus_addr == ADR) ?
                  (((spin_req ? 0 : ed) << 4) | (int'(m_lock) << 3) |
                   (int'(m_arm) << 2) | (int'(m_inv) << 1) | int'(m_ovr)) : 0;
            chk(int'(bus_rdata) == erd, "R8", "bus_rdata model", bus_rdata, erd);
            cnt = (m_n / PRE) % 256;
            ep = (cnt < m_cmp) ^ m_inv;
            chk(pwm_out == ep, "R10", "pwm_out model", pwm_out, ep);
            if (m_n % PER == PER - 1) begin
                c = spin_req ? 15 : ed;
                m_cmp = (c == 15) ? 256 : c * 17;
            end
            m_n++;
            old_arm = m_arm;
            if (bus_wr && bus_addr == ADR) begin
                if (!cfg_lock) begin
                    m_ovr = bus_wdata[0]; m_inv = bus_wdata[1];
                    m_arm = bus_wdata[2]; m_code = int'(bus_wdata[7:4]);
                end
                if (!bus_wdata[3]) m_lock = 0;
            end
            if (hot_evt && old_arm) m_lock = 1;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] d, input bit with_hot);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_wdata = d; hot_evt = with_hot;
        @(posedge clk); #1;
        bus_wr = 1'b0; hot_evt = 1'b0;
    endtask

    task automatic hot_pulse();
        @(posedge clk); #1;
        hot_evt = 1'b1;
        @(posedge clk); #1;
        hot_evt = 1'b0;
    endtask

    task automatic count_high(output int hi);
        hi = 0;
        for (int k = 0; k < PER; k++) begin
            @(negedge clk);
            if (pwm_out) hi++;
        end
        #1;
    endtask

    initial begin
        int hi;
        for (int i = 0; i < NSRC; i++) req[i] = 4'h0;
        step(3);
        chk(bus_rdata == 8'h00, "R1", "reset rdata", bus_rdata, 8'h00);
        chk(duty_code == 4'h0, "R1", "reset duty", duty_code, 0);
        chk(pwm_out == 1'b0, "R1", "reset pwm", pwm_out, 0);
        rst_n = 1'b1;

        req[0] = 4'h3; req[1] = 4'h5; req[2] = 4'h2;
        step(1);
        chk(duty_code == 4'h5, "R3", "max of autos", duty_code, 5);
        wr(8'hA1, 1'b0);
        chk(bus_rdata == 8'hA1, "R2", "override write", bus_rdata, 8'hA1);
        chk(duty_code == 4'hA, "R3", "override wins", duty_code, 4'hA);
        req[1] = 4'hC;
        step(1);
        chk(bus_rdata == 8'hC1, "R8", "live readback", bus_rdata, 8'hC1);
        wr(8'hA5, 1'b0);
        chk(bus_rdata == 8'hC5, "R2", "lock arm field", bus_rdata, 8'hC5);
        hot_pulse();
        chk(bus_rdata == 8'hFD, "R4", "lock set", bus_rdata, 8'hFD);
        chk(duty_code == 4'hF, "R5", "lock full duty", duty_code, 4'hF);
        wr(8'hAD, 1'b0);
        chk(bus_rdata == 8'hFD, "R6", "write 1 no clear", bus_rdata, 8'hFD);
        wr(8'hA5, 1'b0);
        chk(bus_rdata == 8'hC5, "R6", "write 0 clears", bus_rdata, 8'hC5);
        wr(8'hA5, 1'b1);
        chk(bus_rdata == 8'hFD, "R6", "event beats clear", bus_rdata, 8'hFD);
        cfg_lock = 1'b1;
        wr(8'h08, 1'b0);
        chk(bus_rdata == 8'hFD, "R7", "protected fields", bus_rdata, 8'hFD);
        wr(8'h00, 1'b0);
        chk(bus_rdata == 8'hC5, "R7", "clear under cfg_lock", bus_rdata, 8'hC5);
        cfg_lock = 1'b0;
        wr(8'hA1, 1'b0);
        hot_pulse();
        chk(bus_rdata == 8'hC1, "R4", "no lock when unarmed", bus_rdata, 8'hC1);

        spin_req = 1'b1;
        step(1);
        chk(bus_rdata[7:4] == 4'h0, "R8", "spin reads zero", bus_rdata[7:4], 0);
        step(2 * PER + 20);
        count_high(hi);
        chk(hi == PER, "R10", "spin full duty", hi, PER);
        spin_req = 1'b0;

        for (int i = 0; i < NSRC; i++) req[i] = 4'h0;
        wr(8'h51, 1'b0);
        step(2 * PER + 20);
        count_high(hi);
        chk(hi == 85 * PRE, "R9", "code 5 high time", hi, 85 * PRE);
        wr(8'h53, 1'b0);
        step(2 * PER + 20);
        count_high(hi);
        chk(hi == PER - 85 * PRE, "R9", "inverted high time", hi, PER - 85 * PRE);
        wr(8'hF1, 1'b0);
        step(2 * PER + 20);
        count_high(hi);
        chk(hi == PER, "R9", "code F full", hi, PER);
        wr(8'h01, 1'b0);
        step(2 * PER + 20);
        count_high(hi);
        chk(hi == 0, "R9", "code 0 empty", hi, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R1 actual=%0h expected=%0h", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule